// File: doc/BRIEF.md
# Prioritised Multi-Sequence Sample Scheduler

The scheduler owns one shared analog-to-digital converter and time-shares it among four independent sample sequences. Each sequence holds up to 8, 4, 4 or 1 programmed steps. Each step has a channel nibble and a control nibble. A sequence becomes pending when its selected trigger fires and it is enabled. Whenever the converter is free, the pending sequence with the best priority is granted. It then walks its steps from step 0 upward. For each step it presents the channel and control flags to the converter and waits for completion. Each result is forwarded tagged with its sequence and step number. A step can also raise that sequence's interrupt status bit.

Software configures the block through a small word-addressed register port. The registers hold the enables, the trigger selects, the priorities, the per-sequence step channel and control words, and the interrupt mask and status. A software trigger register is also provided. The converter is outside the block. It is reached through a request/done handshake that returns one result word per request.

Top module: `sched_top`

## Requirements
- R1: After reset every register reads 0, `conv_req`, `res_valid` and `irq` are low.
- R2: A granted sequence executes its steps in ascending order from step 0. For step k it drives `conv_chan` from bits [4k+3:4k] of its channel word and `conv_ctl` from the same bits of its control word. `conv_req` and `conv_seq` are held until `conv_done`.
- R3: A sequence stops after the step whose control bit 1 (end) is set. If no step sets it, the sequence stops after its last step (depth 8, 4, 4, 1 for sequences 0..3).
- R4: When the converter is free, the highest-priority pending sequence is granted (value 0 best, ties to the lower index). A running sequence is never pre-empted.
- R5: Trigger select code 0 is software, codes 1..8 are a rising edge on `hw_trig[code-1]`, and code 15 is always asserted. Codes 9..14 never trigger. A level held high triggers once.
- R6: Writing a value with bit n set to the software trigger register starts sequence n only if it is enabled and its select code is 0.
- R7: A sequence whose enable bit is clear ignores all triggers, and its pending request is dropped.
- R8: A sequence with code 15 re-runs back to back. At each sequence boundary it yields to a pending sequence of higher priority.
- R9: Completing a step whose control bit 2 is set raises raw status bit n. `irq` is raw AND mask. Writing 1 to a raw status bit clears it, but a raise in the same cycle wins.
- R10: One cycle after each accepted `conv_done`, `res_valid` pulses for one cycle. The pulse carries the sequence, the step and `conv_result`.
- R11: Register map (address: content): 0 enable[3:0]; 1 trigger select, 4 bits at 4n; 2 priority, 2 bits at 4n; 3 software trigger (reads 0); 4 mask; 5 raw status; 6 masked status; 8+2n channel word; 9+2n control word of sequence n. Writes read back within the implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| hw_trig | input | 8 | Hardware trigger inputs for select codes 1..8 |
| conv_req | output | 1 | Conversion request, held until done |
| conv_seq | output | 2 | Sequence owning the current request |
| conv_chan | output | 4 | Channel select of the current step |
| conv_ctl | output | 4 | Control flags of the current step (bit0 differential, bit1 end, bit2 interrupt, bit3 temperature) |
| conv_done | input | 1 | Conversion complete, qualifies conv_result |
| conv_result | input | RES_W | Converter result |
| res_valid | output | 1 | Result strobe |
| res_seq | output | 2 | Sequence of the result |
| res_step | output | 3 | Step of the result |
| res_data | output | RES_W | Result value |
| irq | output | 4 | Masked interrupt per sequence |

## Verification
The delicate collision is between a step that raises its interrupt status bit and a software write-1-clear of that bit in the same cycle. The bench takes manual control of the converter handshake and asserts `conv_done` on the very edge where the clearing write lands. It then expects the bit to read back as set. A second overlap, a higher-priority trigger arriving while a long sequence is running or while an always-triggered sequence keeps re-arming, is judged by the order of the tagged result stream. The stream must show the running sequence finishing all its steps before the other one appears.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int NSEQ    = 4;
    localparam int MAXSTEP = 8;
    localparam int NIB     = 4;
    localparam int NHW     = 8;
    localparam int PRIO_W  = 2;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int SEQ_W   = $clog2(NSEQ);
    localparam int STEP_W  = $clog2(MAXSTEP);
    localparam int WORD_W  = MAXSTEP * NIB;

    // control nibble bit positions
    localparam int CTL_DIFF = 0;
    localparam int CTL_END  = 1;
    localparam int CTL_IE   = 2;
    localparam int CTL_TEMP = 3;

    // trigger select codes
    localparam logic [NIB-1:0] TRG_SW     = 4'd0;
    localparam logic [NIB-1:0] TRG_HW_HI  = 4'd8;
    localparam logic [NIB-1:0] TRG_ALWAYS = 4'd15;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_ENABLE  = 4'd0;
    localparam logic [ADDR_W-1:0] A_TRIGSEL = 4'd1;
    localparam logic [ADDR_W-1:0] A_PRIO    = 4'd2;
    localparam logic [ADDR_W-1:0] A_SWTRIG  = 4'd3;
    localparam logic [ADDR_W-1:0] A_MASK    = 4'd4;
    localparam logic [ADDR_W-1:0] A_RAW     = 4'd5;
    localparam logic [ADDR_W-1:0] A_MSTAT   = 4'd6;

    typedef enum logic {W_IDLE, W_RUN} walk_st_t;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [STEP_W-1:0] step;
        logic [NIB-1:0]    chan;
        logic [NIB-1:0]    ctl;
    } step_cmd_t;

    function automatic int seq_depth(input int s);
        case (s)
            0:       return 8;
            1, 2:    return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/sched_regs.sv
module sched_regs
    import sched_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    input  logic [NSEQ-1:0]               irq_set,
    output logic [NSEQ-1:0]               en,
    output logic [NSEQ-1:0][NIB-1:0]      tsel,
    output logic [NSEQ-1:0][PRIO_W-1:0]   prio,
    output logic [NSEQ-1:0][WORD_W-1:0]   chan_w,
    output logic [NSEQ-1:0][WORD_W-1:0]   ctl_w,
    output logic [NSEQ-1:0]               raw,
    output logic [NSEQ-1:0]               mask,
    output logic [NSEQ-1:0]               sw_fire
);

    logic [NSEQ-1:0]  w1c;
    logic [SEQ_W-1:0] sel;

    assign sel     = addr[SEQ_W:1];
    assign w1c     = (we && addr == A_RAW)    ? wdata[NSEQ-1:0] : '0;
    assign sw_fire = (we && addr == A_SWTRIG) ? wdata[NSEQ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= '0;
            tsel   <= '0;
            prio   <= '0;
            chan_w <= '0;
            ctl_w  <= '0;
            raw    <= '0;
            mask   <= '0;
        end else begin
            raw <= (raw & ~w1c) | irq_set;
            if (we) begin
                if (addr[ADDR_W-1]) begin
                    if (addr[0]) ctl_w[sel]  <= wdata[WORD_W-1:0];
                    else         chan_w[sel] <= wdata[WORD_W-1:0];
                end else begin
                    case (addr)
                        A_ENABLE:  en   <= wdata[NSEQ-1:0];
                        A_MASK:    mask <= wdata[NSEQ-1:0];
                        A_TRIGSEL: for (int s = 0; s < NSEQ; s++) tsel[s] <= wdata[NIB*s +: NIB];
                        A_PRIO:    for (int s = 0; s < NSEQ; s++) prio[s] <= wdata[NIB*s +: PRIO_W];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr[ADDR_W-1]) begin
            rdata[WORD_W-1:0] = addr[0] ? ctl_w[sel] : chan_w[sel];
        end else begin
            case (addr)
                A_ENABLE:  rdata[NSEQ-1:0] = en;
                A_MASK:    rdata[NSEQ-1:0] = mask;
                A_RAW:     rdata[NSEQ-1:0] = raw;
                A_MSTAT:   rdata[NSEQ-1:0] = raw & mask;
                A_TRIGSEL: for (int s = 0; s < NSEQ; s++) rdata[NIB*s +: NIB] = tsel[s];
                A_PRIO:    for (int s = 0; s < NSEQ; s++) rdata[NIB*s +: PRIO_W] = prio[s];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sched_trig.sv
module sched_trig
    import sched_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSEQ-1:0]          en,
    input  logic [NSEQ-1:0][NIB-1:0] tsel,
    input  logic [NSEQ-1:0]          sw_fire,
    input  logic [NHW-1:0]           hw_trig,
    input  logic [NSEQ-1:0]          grant_oh,
    output logic [NSEQ-1:0]          pend
);

    localparam int HIDX_W = $clog2(NHW);

    logic [NHW-1:0] hw_q;
    logic [NHW-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) hw_q <= '0;
        else     hw_q <= hw_trig;
    end

    assign rise = hw_trig & ~hw_q;

    for (genvar s = 0; s < NSEQ; s++) begin : g_seq
        logic              hit;
        logic              pend_q;
        logic [HIDX_W-1:0] hidx;

        assign hidx = HIDX_W'(tsel[s] - 4'd1);

        always_comb begin
            hit = 1'b0;
            if (tsel[s] == TRG_SW)          hit = sw_fire[s];
            else if (tsel[s] == TRG_ALWAYS) hit = 1'b1;
            else if (tsel[s] <= TRG_HW_HI)  hit = rise[hidx];
        end

        always_ff @(posedge clk) begin
            if (rst) pend_q <= 1'b0;
            else     pend_q <= en[s] & ((pend_q & ~grant_oh[s]) | hit);
        end

        assign pend[s] = pend_q;
    end

endmodule

// File: rtl/sched_arb.sv
module sched_arb
    import sched_pkg::*;
(
    input  logic [NSEQ-1:0]             pend,
    input  logic [NSEQ-1:0][PRIO_W-1:0] prio,
    output logic                        any,
    output logic [SEQ_W-1:0]            win
);

    logic [PRIO_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = '1;
        for (int s = 0; s < NSEQ; s++) begin
            if (pend[s] && (!any || prio[s] < best)) begin
                any  = 1'b1;
                win  = SEQ_W'(s);
                best = prio[s];
            end
        end
    end

endmodule

// File: rtl/sched_walk.sv
module sched_walk
    import sched_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        any,
    input  logic [SEQ_W-1:0]            win,
    input  logic [NSEQ-1:0][WORD_W-1:0] chan_w,
    input  logic [NSEQ-1:0][WORD_W-1:0] ctl_w,
    input  logic                        conv_done,
    input  logic [RES_W-1:0]            conv_result,
    output logic                        conv_req,
    output step_cmd_t                   cmd,
    output logic [NSEQ-1:0]             grant_oh,
    output logic [NSEQ-1:0]             irq_set,
    output logic                        res_valid,
    output logic [SEQ_W-1:0]            res_seq,
    output logic [STEP_W-1:0]           res_step,
    output logic [RES_W-1:0]            res_data
);

    walk_st_t          state;
    logic [SEQ_W-1:0]  cur;
    logic [STEP_W-1:0] step;
    logic              last;
    logic              accept;

    always_comb begin
        cmd.seq  = cur;
        cmd.step = step;
        cmd.chan = chan_w[cur][NIB*step +: NIB];
        cmd.ctl  = ctl_w[cur][NIB*step +: NIB];
    end

    assign last     = (step == STEP_W'(seq_depth(int'(cur)) - 1));
    assign conv_req = (state == W_RUN);
    assign accept   = conv_req && conv_done;
    assign grant_oh = (state == W_IDLE && any) ? (NSEQ'(1) << win) : '0;
    assign irq_set  = (accept && cmd.ctl[CTL_IE]) ? (NSEQ'(1) << cur) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= W_IDLE;
            cur       <= '0;
            step      <= '0;
            res_valid <= 1'b0;
            res_seq   <= '0;
            res_step  <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                W_IDLE: begin
                    if (any) begin
                        state <= W_RUN;
                        cur   <= win;
                        step  <= '0;
                    end
                end
                W_RUN: begin
                    if (conv_done) begin
                        res_valid <= 1'b1;
                        res_seq   <= cur;
                        res_step  <= step;
                        res_data  <= conv_result;
                        if (cmd.ctl[CTL_END] || last) state <= W_IDLE;
                        else                          step  <= step + 1'b1;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sched_top.sv
module sched_top
    import sched_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [3:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [7:0]         hw_trig,
    output logic               conv_req,
    output logic [1:0]         conv_seq,
    output logic [3:0]         conv_chan,
    output logic [3:0]         conv_ctl,
    input  logic               conv_done,
    input  logic [RES_W-1:0]   conv_result,
    output logic               res_valid,
    output logic [1:0]         res_seq,
    output logic [2:0]         res_step,
    output logic [RES_W-1:0]   res_data,
    output logic [3:0]         irq
);

    logic [NSEQ-1:0]               en;
    logic [NSEQ-1:0][NIB-1:0]      tsel;
    logic [NSEQ-1:0][PRIO_W-1:0]   prio;
    logic [NSEQ-1:0][WORD_W-1:0]   chan_w;
    logic [NSEQ-1:0][WORD_W-1:0]   ctl_w;
    logic [NSEQ-1:0]               raw;
    logic [NSEQ-1:0]               mask;
    logic [NSEQ-1:0]               sw_fire;
    logic [NSEQ-1:0]               irq_set;
    logic [NSEQ-1:0]               grant_oh;
    logic [NSEQ-1:0]               pend;
    logic                          any;
    logic [SEQ_W-1:0]              win;
    step_cmd_t                     cmd;

    sched_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .irq_set (irq_set),
        .en      (en),
        .tsel    (tsel),
        .prio    (prio),
        .chan_w  (chan_w),
        .ctl_w   (ctl_w),
        .raw     (raw),
        .mask    (mask),
        .sw_fire (sw_fire)
    );

    sched_trig u_trig (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tsel     (tsel),
        .sw_fire  (sw_fire),
        .hw_trig  (hw_trig),
        .grant_oh (grant_oh),
        .pend     (pend)
    );

    sched_arb u_arb (
        .pend (pend),
        .prio (prio),
        .any  (any),
        .win  (win)
    );

    sched_walk #(.RES_W(RES_W)) u_walk (
        .clk         (clk),
        .rst         (rst),
        .any         (any),
        .win         (win),
        .chan_w      (chan_w),
        .ctl_w       (ctl_w),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .conv_req    (conv_req),
        .cmd         (cmd),
        .grant_oh    (grant_oh),
        .irq_set     (irq_set),
        .res_valid   (res_valid),
        .res_seq     (res_seq),
        .res_step    (res_step),
        .res_data    (res_data)
    );

    assign conv_seq  = cmd.seq;
    assign conv_chan = cmd.chan;
    assign conv_ctl  = cmd.ctl;
    assign irq       = raw & mask;

endmodule

// File: rtl/sched_chk.sv
module sched_chk (
    input logic       clk,
    input logic       rst,
    input logic       conv_req,
    input logic       conv_done,
    input logic [1:0] conv_seq,
    input logic [3:0] conv_ctl,
    input logic       res_valid,
    input logic [1:0] res_seq,
    input logic [2:0] res_step,
    input logic [3:0] raw
);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done) |=> (conv_req && $stable(conv_seq)));

    // R10
    res_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && conv_done) |=> res_valid);

    // R10
    res_only_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        !(conv_req && conv_done) |=> !res_valid);

    // R3
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_seq == 2'd0 || res_step < ((res_seq == 2'd3) ? 3'd1 : 3'd4)));

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && conv_done && conv_ctl[2]) |=> raw[$past(conv_seq)]);

endmodule

bind sched_top sched_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_req  (conv_req),
    .conv_done (conv_done),
    .conv_seq  (conv_seq),
    .conv_ctl  (conv_ctl),
    .res_valid (res_valid),
    .res_seq   (res_seq),
    .res_step  (res_step),
    .raw       (raw)
);

// File: tb/test_sched_top.sv
module test_sched_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  hw_trig = '0;
    logic        conv_req;
    logic [1:0]  conv_seq;
    logic [3:0]  conv_chan;
    logic [3:0]  conv_ctl;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic        res_valid;
    logic [1:0]  res_seq;
    logic [2:0]  res_step;
    logic [11:0] res_data;
    logic [3:0]  irq;

    int nchk = 0;
    int nfail = 0;
    int lat = 0;
    int cnt = 0;
    bit manual = 1'b0;
    int nlog = 0;
    int lg_seq [0:511];
    int lg_step [0:511];
    logic [11:0] lg_data [0:511];

    always #2 clk = ~clk;

    sched_top i_sched_top (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_trig(hw_trig),
        .conv_req(conv_req), .conv_seq(conv_seq), .conv_chan(conv_chan),
        .conv_ctl(conv_ctl), .conv_done(conv_done), .conv_result(conv_result),
        .res_valid(res_valid), .res_seq(res_seq), .res_step(res_step),
        .res_data(res_data), .irq(irq)
    );

    // converter model: result = {2'b00, seq, ctl, chan}
    initial forever begin
        @(negedge clk);
        if (!manual) begin
            if (conv_done) conv_done = 1'b0;
            else if (conv_req) begin
                if (cnt >= lat) begin
                    conv_done   = 1'b1;
                    conv_result = {2'b00, conv_seq, conv_ctl, conv_chan};
                    cnt = 0;
                end else cnt++;
            end
        end
    end

    initial forever begin
        @(negedge clk);
        if (res_valid && nlog < 512) begin
            lg_seq[nlog]  = int'(res_seq);
            lg_step[nlog] = int'(res_step);
            lg_data[nlog] = res_data;
            nlog++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        int q = 0;
        while (q < 4) begin
            @(negedge clk);
            if (!conv_req && !res_valid) q++;
            else q = 0;
        end
    endtask

    function automatic int bdepth(input int s);
        return (s == 0) ? 8 : (s == 3) ? 1 : 4;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] mw, cw;
        int expn, n3, n1, pos1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 16; a++) rd_chk(4'(a), 32'h0, "R1 reg");
        chk(!conv_req && !res_valid && irq == 0, "R1 outputs", {conv_req, res_valid, irq}, 0);

        // R11 register readback
        wr(4'd0, 32'hA);       rd_chk(4'd0, 32'hA, "R11 enable");
        wr(4'd0, 32'h0);
        wr(4'd1, 32'hF5A3);    rd_chk(4'd1, 32'hF5A3, "R11 trigsel");
        wr(4'd2, 32'hFFFF);    rd_chk(4'd2, 32'h3333, "R11 prio");
        wr(4'd2, 32'h0);
        wr(4'd4, 32'h5);       rd_chk(4'd4, 32'h5, "R11 mask");
        wr(4'd4, 32'h0);
        rd_chk(4'd3, 32'h0, "R11 swtrig reads 0");
        for (int s = 0; s < 4; s++) begin
            wr(4'(8 + 2*s), 32'h12345678 + s);
            wr(4'(9 + 2*s), 32'h87654321 - s);
            rd_chk(4'(8 + 2*s), 32'h12345678 + s, "R11 chan word");
            rd_chk(4'(9 + 2*s), 32'h87654321 - s, "R11 ctl word");
        end
        wr(4'd1, 32'h0);

        // R2 R3 step walk sweep over every end position of every sequence
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e <= bdepth(s); e++) begin
                mw = 0; cw = 0;
                for (int k = 0; k < 8; k++) begin
                    mw[4*k +: 4] = 4'((s*5 + k*3) & 15);
                    cw[4*k +: 4] = 4'(((k == e) ? 2 : 0) | (k & 1));
                end
                wr(4'd0, 0);
                wr(4'(8 + 2*s), mw);
                wr(4'(9 + 2*s), cw);
                wr(4'd0, 32'(1 << s));
                lat = (s + e) % 3;
                nlog = 0;
                wr(4'd3, 32'(1 << s));
                wait_idle();
                expn = (e < bdepth(s)) ? e + 1 : bdepth(s);
                chk(nlog == expn, "R3 step count", nlog, expn);
                for (int k = 0; k < expn; k++) begin
                    chk(lg_seq[k] == s, "R10 result seq", lg_seq[k], s);
                    chk(lg_step[k] == k, "R2 step order", lg_step[k], k);
                    chk(lg_data[k] == {2'b00, 2'(s), cw[4*k +: 4], mw[4*k +: 4]},
                        "R2 chan/ctl per step", lg_data[k], {2'b00, 2'(s), cw[4*k +: 4], mw[4*k +: 4]});
                end
            end
        end

        // single-step configs for every sequence: step 0 has END, channel = seq
        wr(4'd0, 0);
        for (int s = 0; s < 4; s++) begin
            wr(4'(8 + 2*s), 32'(s));
            wr(4'(9 + 2*s), 32'h2);
        end
        lat = 1;

        // R6 software trigger gating
        wr(4'd1, 32'h1000); wr(4'd0, 32'h8);
        nlog = 0; wr(4'd3, 32'h8); wait_idle();
        chk(nlog == 0, "R6 sw ignored on hw code", nlog, 0);
        wr(4'd1, 32'h0);
        nlog = 0; wr(4'd3, 32'h4); wait_idle();
        chk(nlog == 0, "R6 sw ignored when disabled", nlog, 0);
        nlog = 0; wr(4'd3, 32'h8); wait_idle();
        chk(nlog == 1 && lg_seq[0] == 3, "R6 sw start", nlog, 1);

        // R5 hardware trigger codes 1..8 and wrong-input rejection
        for (int k = 1; k <= 8; k++) begin
            wr(4'd1, 32'(k << 12));
            nlog = 0;
            @(negedge clk); hw_trig = 8'(~(1 << (k-1)));
            @(negedge clk); hw_trig = 0;
            wait_idle();
            chk(nlog == 0, "R5 other inputs ignored", nlog, 0);
            @(negedge clk); hw_trig = 8'(1 << (k-1));
            @(negedge clk); hw_trig = 0;
            wait_idle();
            chk(nlog == 1, "R5 hw edge code", nlog, 1);
        end
        wr(4'd1, 32'h5000); nlog = 0;
        @(negedge clk); hw_trig = 8'h10;
        repeat (30) @(negedge clk);
        hw_trig = 0; wait_idle();
        chk(nlog == 1, "R5 held level triggers once", nlog, 1);
        for (int k = 9; k <= 14; k++) begin
            wr(4'd1, 32'(k << 12)); nlog = 0;
            @(negedge clk); hw_trig = 8'hFF;
            @(negedge clk); hw_trig = 0;
            wait_idle();
            chk(nlog == 0, "R5 unused code never triggers", nlog, 0);
        end

        // R7 disabled sequence ignores triggers
        wr(4'd0, 32'h0); wr(4'd1, 32'h1000); nlog = 0;
        @(negedge clk); hw_trig = 8'h01;
        @(negedge clk); hw_trig = 0;
        wr(4'd1, 32'hF000);
        repeat (20) @(negedge clk);
        chk(nlog == 0, "R7 disabled ignores triggers", nlog, 0);

        // R4 every unique priority permutation, all four pending together
        wr(4'd1, 0); wr(4'd0, 32'hF);
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
              for (int d = 0; d < 4; d++) begin
                int pr [4];
                if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
                pr[0] = a; pr[1] = b; pr[2] = c; pr[3] = d;
                wr(4'd2, 32'(a | (b << 4) | (c << 8) | (d << 12)));
                nlog = 0; wr(4'd3, 32'hF); wait_idle();
                chk(nlog == 4, "R4 all run", nlog, 4);
                for (int r = 0; r < 4; r++)
                    for (int s = 0; s < 4; s++)
                        if (pr[s] == r) chk(lg_seq[r] == s, "R4 priority order", lg_seq[r], s);
              end
        wr(4'd2, 0); nlog = 0; wr(4'd3, 32'hF); wait_idle();
        for (int r = 0; r < 4; r++) chk(lg_seq[r] == r, "R4 tie to lower index", lg_seq[r], r);

        // R4 no pre-emption: sequence 0 (lowest) runs 8 steps, sequence 3 (highest) arrives mid-run
        wr(4'd9, 32'h0); wr(4'd2, 32'h0123); lat = 2;
        nlog = 0; wr(4'd3, 32'h1);
        repeat (6) @(negedge clk);
        wr(4'd3, 32'h8); wait_idle();
        chk(nlog == 9, "R4 no preemption count", nlog, 9);
        for (int k = 0; k < 8; k++) chk(lg_seq[k] == 0 && lg_step[k] == k, "R4 running seq completes", lg_step[k], k);
        chk(lg_seq[8] == 3, "R4 waiting seq after", lg_seq[8], 3);
        wr(4'd9, 32'h2);

        // R8 always-asserted trigger with a higher-priority interloper
        wr(4'd0, 0); wr(4'd2, 32'h3201); wr(4'd1, 32'hF000); lat = 1;
        nlog = 0; wr(4'd0, 32'hA);
        repeat (100) @(negedge clk);
        chk(nlog >= 10, "R8 continuous re-run", nlog, 10);
        nlog = 0; wr(4'd3, 32'h2);
        repeat (20) @(negedge clk);
        wr(4'd0, 0); wait_idle();
        n1 = 0; n3 = 0; pos1 = -1;
        for (int i = 0; i < nlog; i++) begin
            if (lg_seq[i] == 1) begin n1++; pos1 = i; end
            if (lg_seq[i] == 3) n3++;
        end
        chk(n1 == 1, "R8 interloper runs once", n1, 1);
        chk(pos1 >= 0 && pos1 < nlog - 1 && lg_seq[pos1 + 1] == 3, "R8 resumes after yield", pos1, 0);
        nlog = 0; repeat (20) @(negedge clk);
        chk(nlog == 0, "R7 disable stops always trigger", nlog, 0);

        // R9 interrupt status, mask, clear, and raise-vs-clear collision
        wr(4'd1, 0); wr(4'd9 + 4'd6, 32'h6); wr(4'd4, 0); wr(4'd5, 32'hF);
        manual = 1'b1; conv_done = 1'b0;
        wr(4'd0, 32'h8); wr(4'd3, 32'h8);
        repeat (3) @(negedge clk);
        chk(conv_req == 1'b1 && conv_seq == 2'd3, "R2 request held", conv_req, 1);
        conv_done = 1'b1; conv_result = 12'h5A5;
        @(negedge clk); conv_done = 1'b0;
        chk(res_valid && res_data == 12'h5A5 && res_seq == 2'd3, "R10 result carried", res_data, 12'h5A5);
        rd_chk(4'd5, 32'h8, "R9 raw set");
        chk(irq == 0, "R9 masked off", irq, 0);
        rd_chk(4'd6, 32'h0, "R9 masked status off");
        wr(4'd4, 32'h8);
        chk(irq == 4'h8, "R9 irq when masked in", irq, 8);
        rd_chk(4'd6, 32'h8, "R9 masked status");
        wr(4'd5, 32'h8);
        chk(irq == 0, "R9 w1c clears irq", irq, 0);
        rd_chk(4'd5, 32'h0, "R9 w1c clears raw");
        wr(4'd3, 32'h8);
        repeat (3) @(negedge clk);
        conv_done = 1'b1; reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h8;
        @(negedge clk);
        conv_done = 1'b0; reg_we = 1'b0;
        rd_chk(4'd5, 32'h8, "R9 raise wins over clear");
        wr(4'd5, 32'h1);
        rd_chk(4'd5, 32'h8, "R9 clear of other bit no effect");
        wr(4'd5, 32'h8);
        rd_chk(4'd5, 32'h0, "R9 cleared");
        manual = 1'b0;

        finish_run();
    end

endmodule